// File: doc/BRIEF.md
# Programmable Clock Divider and Output Router

This block derives output clocks from a single reference clock. It divides the reference by a 6-bit ratio that may be odd or even, and the result keeps a 50% duty cycle at every ratio. It also makes a fixed half-rate clock. One of these clocks is routed to the main clock output. A second router feeds a shared pin, and that pin can instead act as an output-enable input or a power-down input.

Configuration is written through a single strobe and first held in a staging register. The new settings take effect only when the current divided period ends, so no output pulse is cut short. While the block is powered down, the settings take effect at once. The pad drive-strength code is kept with the other settings and comes out as a registered 2-bit value.

Top module: `clkdiv_sel`

## Requirements
- R1: After reset the ratio is 1, the main source is the divided clock, the secondary source is the main-output copy, the pin mode is output-enable and the drive code is 1. With these settings `clk0_o` follows the reference, `clk0_oe`=1 and `pin_oe`=0.
- R2: Main source codes are 0 for the reference, 1 for the reference divided by two and 2 for the reference divided by the ratio. Reserved code 3 is stored as 0.
- R3: Secondary source codes are 0 for the reference, 1 for the half-rate clock and 2 for a copy of the main output. Reserved code 3 is stored as 0. The secondary clock appears on `pin_o` with `pin_oe`=1 only in pin mode 2.
- R4: A ratio P from 2 to 63 gives a main-output period of P reference cycles with a high time of exactly P reference half-cycles. This holds for odd P as well as even P. A ratio of 0 behaves as 1.
- R5: A configuration write takes effect at the end of the divided period in progress, or on the next edge while powered down. The divided output is never truncated.
- R6: Pin modes are 0 for output-enable, 1 for power-down and 2 for secondary clock output. Reserved code 3 is stored as 0. `pin_i` passes through a 2-flop synchronizer whose reset value is 1.
- R7: In mode 0, a low on `pin_i` drives `clk0_oe` to 0 two rising edges later. A high on `pin_i` restores it to 1 after the same delay.
- R8: In mode 1, a low on `pin_i` holds the counters and the half-rate clock and keeps `clk0_o` low.
- R9: On leaving power-down, the divider restarts from the start of a period. `clk0_o` is low after the second rising edge that follows the pin rising, and it first rises at the third such edge.
- R10: Drive codes are 0 for 4 mA, 1 for 8 mA and 2 for 16 mA. Reserved code 3 is stored as 1.
- R11: In mode 2, `pin_i` is ignored: `clk0_oe` stays 1 and the clocks keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Strobe that loads the staging register |
| cfg_ratio | input | 6 | Divide ratio |
| cfg_src0 | input | 2 | Main output source code |
| cfg_src1 | input | 2 | Secondary output source code |
| cfg_pinmode | input | 2 | Shared pin function code |
| cfg_drive | input | 2 | Drive strength code |
| pin_i | input | 1 | Level received from the shared pin |
| clk0_o | output | 1 | Main clock output |
| clk0_oe | output | 1 | Enable for the main output driver (0 means high impedance) |
| pin_o | output | 1 | Secondary clock toward the shared pin |
| pin_oe | output | 1 | Enable for the shared pin driver |
| drive_o | output | 2 | Registered drive-strength code for the pads |

## Verification
Each result has a fixed delay after its stimulus:
- The output enable follows the pin two rising edges later, because of the synchronizer.
- After power-down is released, the divided clock is low for the first two edges and rises at the third.
- Settings written while powered up appear only after the current divided period ends.

The bench drives inputs on falling edges. It samples 2 ns after each clock edge, in the middle of every half-cycle. Period and duty are measured by counting high samples and rising transitions over a window of exactly four output periods. That count does not depend on phase, and each setting change is followed by a settling wait longer than the longest period.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam logic [1:0] S0_REF  = 2'd0;
  localparam logic [1:0] S0_HALF = 2'd1;
  localparam logic [1:0] S0_DIVP = 2'd2;

  localparam logic [1:0] S1_REF  = 2'd0;
  localparam logic [1:0] S1_HALF = 2'd1;
  localparam logic [1:0] S1_MAIN = 2'd2;

  localparam logic [1:0] PM_OE   = 2'd0;
  localparam logic [1:0] PM_PD   = 2'd1;
  localparam logic [1:0] PM_CLK  = 2'd2;

  localparam logic [1:0] DRV_4   = 2'd0;
  localparam logic [1:0] DRV_8   = 2'd1;
  localparam logic [1:0] DRV_16  = 2'd2;

  typedef struct packed {
    logic [1:0] src0;
    logic [1:0] src1;
    logic [1:0] mode;
    logic [1:0] drive;
  } route_t;

  localparam route_t ROUTE_RST = '{src0: S0_DIVP, src1: S1_MAIN, mode: PM_OE, drive: DRV_8};

  function automatic route_t clean_route(input route_t r);
    route_t o;
    o = r;
    if (r.src0 == 2'd3)  o.src0  = S0_REF;
    if (r.src1 == 2'd3)  o.src1  = S1_REF;
    if (r.mode == 2'd3)  o.mode  = PM_OE;
    if (r.drive == 2'd3) o.drive = DRV_8;
    return o;
  endfunction

endpackage

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg
  import clkdiv_pkg::*;
#(
  parameter int RW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [RW-1:0] wr_ratio,
  input  route_t        wr_route,
  input  logic          run,
  input  logic          wrap,
  output logic [RW-1:0] act_ratio,
  output logic [RW-1:0] nxt_ratio,
  output route_t        act_route
);

  localparam logic [RW-1:0] RATIO_RST = RW'(1);

  logic [RW-1:0] pend_ratio;
  route_t        pend_route;
  logic          pend_v;
  logic          apply;

  assign apply     = pend_v && (wrap || !run);
  assign nxt_ratio = apply ? pend_ratio : act_ratio;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v     <= 1'b0;
      pend_ratio <= RATIO_RST;
      pend_route <= ROUTE_RST;
      act_ratio  <= RATIO_RST;
      act_route  <= ROUTE_RST;
    end else begin
      if (apply) begin
        act_ratio <= pend_ratio;
        act_route <= pend_route;
      end
      if (cfg_wr) begin
        pend_ratio <= wr_ratio;
        pend_route <= clean_route(wr_route);
        pend_v     <= 1'b1;
      end else if (apply) begin
        pend_v <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/clkdiv_pin.sv
module clkdiv_pin
  import clkdiv_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_i,
  input  logic [1:0] mode,
  output logic       run,
  output logic       main_oe,
  output logic       pin_drv
);

  logic [SYNC-1:0] sync_q;
  logic            pin_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC-2:0], pin_i};
  end

  assign pin_q   = sync_q[SYNC-1];
  assign run     = !((mode == PM_PD) && !pin_q);
  assign main_oe = !((mode == PM_OE) && !pin_q);
  assign pin_drv = (mode == PM_CLK);

endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
  parameter int RW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [RW-1:0] act_ratio,
  input  logic [RW-1:0] nxt_ratio,
  output logic [RW-1:0] cnt,
  output logic          wrap,
  output logic          divp,
  output logic          half,
  output logic          ref_g
);

  localparam logic [RW-1:0] ONE = RW'(1);

  logic [RW-1:0] eff_act, eff_nxt, cnt_nxt, hi_nxt;
  logic          rise_q, fall_q, run_n;
  logic          bypass, odd;

  assign eff_act = (act_ratio == '0) ? ONE : act_ratio;
  assign eff_nxt = (nxt_ratio == '0) ? ONE : nxt_ratio;
  assign wrap    = run && (cnt >= eff_act - ONE);
  assign cnt_nxt = wrap ? '0 : cnt + ONE;
  assign hi_nxt  = eff_nxt >> 1;
  assign bypass  = (eff_act == ONE);
  assign odd     = eff_act[0] && !bypass;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      rise_q <= 1'b0;
      half   <= 1'b0;
    end else if (!run) begin
      cnt    <= eff_nxt - ONE;
      rise_q <= 1'b0;
      half   <= 1'b0;
    end else begin
      cnt    <= cnt_nxt;
      rise_q <= (cnt_nxt < hi_nxt);
      half   <= ~half;
    end
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      fall_q <= 1'b0;
      run_n  <= 1'b0;
    end else begin
      fall_q <= rise_q;
      run_n  <= run;
    end
  end

  assign ref_g = clk & run_n;
  assign divp  = bypass ? ref_g : (odd ? (rise_q | fall_q) : rise_q);

endmodule

// File: rtl/clkdiv_sel.sv
module clkdiv_sel
  import clkdiv_pkg::*;
#(
  parameter int RATIO_W     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic [RATIO_W-1:0] cfg_ratio,
  input  logic [1:0]         cfg_src0,
  input  logic [1:0]         cfg_src1,
  input  logic [1:0]         cfg_pinmode,
  input  logic [1:0]         cfg_drive,
  input  logic               pin_i,
  output logic               clk0_o,
  output logic               clk0_oe,
  output logic               pin_o,
  output logic               pin_oe,
  output logic [1:0]         drive_o
);

  logic [RATIO_W-1:0] act_ratio, nxt_ratio, cnt;
  route_t             act_route, wr_route;
  logic [1:0]         act_mode;
  logic               run, wrap, divp, half, ref_g, pin_drv, clk1;

  assign wr_route = '{src0: cfg_src0, src1: cfg_src1, mode: cfg_pinmode, drive: cfg_drive};
  assign act_mode = act_route.mode;

  clkdiv_cfg #(.RW(RATIO_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .wr_ratio(cfg_ratio), .wr_route(wr_route),
    .run(run), .wrap(wrap), .act_ratio(act_ratio), .nxt_ratio(nxt_ratio), .act_route(act_route)
  );

  clkdiv_pin #(.SYNC(SYNC_STAGES)) u_pin (
    .clk(clk), .rst(rst), .pin_i(pin_i), .mode(act_mode),
    .run(run), .main_oe(clk0_oe), .pin_drv(pin_drv)
  );

  clkdiv_core #(.RW(RATIO_W)) u_core (
    .clk(clk), .rst(rst), .run(run), .act_ratio(act_ratio), .nxt_ratio(nxt_ratio),
    .cnt(cnt), .wrap(wrap), .divp(divp), .half(half), .ref_g(ref_g)
  );

  always_comb begin
    case (act_route.src0)
      S0_HALF: clk0_o = half;
      S0_DIVP: clk0_o = divp;
      default: clk0_o = ref_g;
    endcase
  end

  always_comb begin
    case (act_route.src1)
      S1_HALF: clk1 = half;
      S1_MAIN: clk1 = clk0_o;
      default: clk1 = ref_g;
    endcase
  end

  assign pin_o   = pin_drv & clk1;
  assign pin_oe  = pin_drv;
  assign drive_o = act_route.drive;

endmodule

// File: rtl/clkdiv_sel_chk.sv
module clkdiv_sel_chk #(
  parameter int RW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          pin_i,
  input logic          clk0_o,
  input logic          clk0_oe,
  input logic [1:0]    mode,
  input logic          run,
  input logic [RW-1:0] cnt,
  input logic [RW-1:0] act_ratio,
  input logic          half
);

  logic [1:0]    since_rst;
  logic [RW-1:0] eff;

  always_ff @(posedge clk) begin
    if (rst)                   since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assign eff = (act_ratio == '0) ? RW'(1) : act_ratio;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= eff - RW'(1)); // R4

  AST_RATIO_AT_END: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !$stable(act_ratio)) |->
      (!$past(run) || $past(cnt) == $past(eff) - RW'(1))); // R5

  AST_PD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !run && $past(!run)) |-> !clk0_o); // R8

  AST_HALF_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && run && $past(run)) |-> (half != $past(half))); // R2

  AST_OE_FOLLOWS_PIN: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && mode == 2'd0 && !$past(pin_i, 2)) |-> !clk0_oe); // R7

endmodule

bind clkdiv_sel clkdiv_sel_chk #(.RW(RATIO_W)) u_chk (
  .clk(clk), .rst(rst), .pin_i(pin_i), .clk0_o(clk0_o), .clk0_oe(clk0_oe),
  .mode(act_mode), .run(run), .cnt(cnt), .act_ratio(act_ratio), .half(half)
);

// File: tb/sim_clkdiv_sel.sv
module sim_clkdiv_sel;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [5:0] cfg_ratio = '0;
  logic [1:0] cfg_src0 = '0, cfg_src1 = '0, cfg_pinmode = '0, cfg_drive = '0;
  logic       pin_i = 1'b1;
  logic       clk0_o, clk0_oe, pin_o, pin_oe;
  logic [1:0] drive_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  clkdiv_sel u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_ratio(cfg_ratio), .cfg_src0(cfg_src0),
    .cfg_src1(cfg_src1), .cfg_pinmode(cfg_pinmode), .cfg_drive(cfg_drive), .pin_i(pin_i),
    .clk0_o(clk0_o), .clk0_oe(clk0_oe), .pin_o(pin_o), .pin_oe(pin_oe), .drive_o(drive_o)
  );

  // {ratio, src0, src1, clk0 period in half-cycles, secondary period in half-cycles}
  localparam int NV = 10;
  localparam logic [25:0] VEC [NV] = '{
    {6'd1,  2'd2, 2'd2, 8'd2,   8'd2},
    {6'd2,  2'd2, 2'd1, 8'd4,   8'd4},
    {6'd3,  2'd2, 2'd2, 8'd6,   8'd6},
    {6'd4,  2'd1, 2'd0, 8'd4,   8'd2},
    {6'd5,  2'd2, 2'd0, 8'd10,  8'd2},
    {6'd0,  2'd2, 2'd2, 8'd2,   8'd2},
    {6'd63, 2'd2, 2'd2, 8'd126, 8'd126},
    {6'd62, 2'd0, 2'd2, 8'd2,   8'd2},
    {6'd7,  2'd3, 2'd3, 8'd2,   8'd2},
    {6'd6,  2'd2, 2'd1, 8'd12,  8'd4}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [5:0] r, input logic [1:0] s0, input logic [1:0] s1,
                     input logic [1:0] m, input logic [1:0] d);
    @(negedge clk);
    cfg_ratio = r; cfg_src0 = s0; cfg_src1 = s1; cfg_pinmode = m; cfg_drive = d;
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  function automatic logic pick(input int which);
    return (which == 0) ? clk0_o : pin_o;
  endfunction

  task automatic measure(input int which, input int halves, output int highs, output int rises);
    logic prev, cur;
    highs = 0; rises = 0;
    @(posedge clk); #2;
    prev = pick(which);
    for (int i = 0; i < halves; i++) begin
      #5;
      cur = pick(which);
      if (cur) highs++;
      if (cur && !prev) rises++;
      prev = cur;
    end
  endtask

  task automatic settle();
    repeat (150) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int h, r, p0, p1;
    logic prev, cur;

    // reset state
    repeat (3) @(posedge clk); #2;
    chk("R1 clk0_oe", clk0_oe, 1);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 drive", drive_o, 1);
    @(negedge clk); rst = 1'b0;
    repeat (5) @(posedge clk);
    measure(0, 8, h, r);
    chk("R1 ref highs", h, 4);
    chk("R1 ref rises", r, 4);

    // drive code mapping
    cfg(6'd1, 2'd2, 2'd2, 2'd0, 2'd2);
    repeat (4) @(posedge clk); #2;
    chk("R10 drive 16mA", drive_o, 2);
    cfg(6'd1, 2'd2, 2'd2, 2'd0, 2'd3);
    repeat (4) @(posedge clk); #2;
    chk("R10 drive reserved", drive_o, 1);
    cfg(6'd1, 2'd2, 2'd2, 2'd0, 2'd0);
    repeat (4) @(posedge clk); #2;
    chk("R10 drive 4mA", drive_o, 0);

    // vector table, pin mode = secondary clock
    for (int v = 0; v < NV; v++) begin
      cfg(VEC[v][25:20], VEC[v][19:18], VEC[v][17:16], 2'd2, 2'd1);
      settle();
      p0 = int'(VEC[v][15:8]);
      p1 = int'(VEC[v][7:0]);
      #2;
      chk("R3 pin_oe in clock mode", pin_oe, 1);
      measure(0, 4 * p0, h, r);
      chk("R2 R4 clk0 highs", h, 2 * p0);
      chk("R2 R4 clk0 rises", r, 4);
      measure(1, 4 * p1, h, r);
      chk("R3 pin_o highs", h, 2 * p1);
      chk("R3 pin_o rises", r, 4);
    end

    // output-enable mode
    cfg(6'd4, 2'd2, 2'd2, 2'd0, 2'd1);
    settle();
    @(negedge clk); pin_i = 1'b0;
    @(posedge clk); #2;
    chk("R7 oe after one edge", clk0_oe, 1);
    @(posedge clk); #2;
    chk("R7 oe after two edges", clk0_oe, 0);
    chk("R6 pin_oe in oe mode", pin_oe, 0);
    @(negedge clk); pin_i = 1'b1;
    repeat (2) @(posedge clk); #2;
    chk("R7 oe restored", clk0_oe, 1);

    // power-down mode
    cfg(6'd4, 2'd2, 2'd2, 2'd1, 2'd1);
    settle();
    @(negedge clk); pin_i = 1'b0;
    repeat (5) @(posedge clk);
    measure(0, 40, h, r);
    chk("R8 clk0 held low", h, 0);
    chk("R6 oe unaffected by pd", clk0_oe, 1);
    @(negedge clk); pin_i = 1'b1;
    @(posedge clk); #2; chk("R9 edge0", clk0_o, 0);
    @(posedge clk); #2; chk("R9 edge1", clk0_o, 0);
    @(posedge clk); #2; chk("R9 edge2", clk0_o, 1);
    @(posedge clk); #2; chk("R9 edge3", clk0_o, 1);
    @(posedge clk); #2; chk("R9 edge4", clk0_o, 0);
    @(posedge clk); #2; chk("R9 edge5", clk0_o, 0);
    @(posedge clk); #2; chk("R9 edge6", clk0_o, 1);

    // secondary clock mode ignores the pin level
    cfg(6'd3, 2'd2, 2'd2, 2'd2, 2'd1);
    settle();
    @(negedge clk); pin_i = 1'b0;
    repeat (5) @(posedge clk); #2;
    chk("R11 oe stays", clk0_oe, 1);
    measure(0, 24, h, r);
    chk("R11 clk0 highs", h, 12);
    chk("R11 clk0 rises", r, 4);
    @(negedge clk); pin_i = 1'b1;

    // ratio change waits for the period end
    cfg(6'd63, 2'd2, 2'd2, 2'd2, 2'd1);
    settle();
    @(posedge clk); #2;
    prev = clk0_o;
    for (int i = 0; i < 400; i++) begin
      #5;
      cur = clk0_o;
      if (cur && !prev) break;
      prev = cur;
    end
    cfg(6'd2, 2'd2, 2'd2, 2'd2, 2'd1);
    repeat (20) @(posedge clk); #2;
    chk("R5 old period kept", clk0_o, 1);
    settle();
    measure(0, 16, h, r);
    chk("R5 new ratio highs", h, 8);
    chk("R5 new ratio rises", r, 4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule